// File: doc/BRIEF.md
# Oversampled Serial Receiver with Receive Queue

This block receives a fixed asynchronous serial frame: one start bit, eight data bits sent least significant bit first, no parity, and one stop bit. It samples the line fourteen times per bit period. The line input first passes through a two-flop synchronizer. A falling edge starts a frame only if the line is still low at the middle of the start bit. Each data bit and the stop bit are then taken at the middle of their own periods. Completed bytes enter a 64-entry receive queue. A host pops the queue one 32-bit word at a time. Each word carries the byte and its empty, framing and break flags.

Two receive interrupt sources are defined. The first is a trigger condition, raised when the queue level reaches a threshold chosen by a code. The second is an inactivity timeout, raised when data waits in the queue while the line stays quiet for a chosen number of character times. Three sticky error flags record overrun, break and framing error. The host clears each one by writing a 1 to its bit. The interrupt output is the OR of the sources that are enabled. The sample tick is set by an 8-bit divisor. The trigger-level code and the timeout code are plain inputs.

The receiver is a state machine with five states:
- RX_IDLE waits for a low line.
- RX_START counts to the middle of the start bit. It goes to RX_DATA if the line is low there, and back to RX_IDLE if it is not (a glitch).
- RX_DATA takes eight bit samples and then moves to RX_STOP.
- RX_STOP samples the stop bit and pushes the byte. It returns to RX_IDLE if the stop bit is high. If the stop bit is low it goes to RX_RECOVER.
- RX_RECOVER waits for the line to go high, then returns to RX_IDLE.

Top module: `serial_rx_core`

## Requirements
- R1: One sample tick occurs every (rate_div + 1) clock cycles, and one bit lasts 14 ticks. Bytes are received correctly at every divisor setting.
- R2: A frame starts only when the synchronized line is still low at the 7th tick after the falling edge. A low pulse much shorter than half a bit pushes nothing.
- R3: rd_word holds the queue head as follows:
  - bits 7:0 hold the byte;
  - bit 9 is the framing flag;
  - bit 10 is the break flag;
  - bits 31:11 are zero.
  When the queue is empty, rd_word reads 0x100 (bit 8 set), and rd_en has no effect.
- R4: The trigger code selects the threshold: codes 0 to 5 select 1, 4, 8, 16, 32 and 48 bytes, and codes 6 and 7 also select 48. status bit 1 is high while level is at or above the threshold.
- R5: The timeout code selects the delay: code 0 disables the timeout, and codes 1, 2 and 3 select 4, 8 and 16 character times of 140 ticks each. status bit 2 rises after that many ticks with a non-empty queue and no line activity. It drops on a pop, on a push, on line activity, or when the queue is empty.
- R6: The sticky flags sit at status bit 5 (overrun), bit 4 (break) and bit 3 (framing). A cycle with clr_wr high and a 1 in the matching clr_data bit clears the flag. A new event in the same cycle wins over the clear.
- R7: A byte that completes while the queue is full is discarded and sets the overrun flag.
- R8: The queue holds 64 bytes in arrival order. level gives the occupancy from 0 to 64.
- R9: A frame with all data bits zero and a low stop bit is a break. The byte is stored with bit 10 set and bit 9 clear, the break flag is set, and the receiver waits for the line to return high before searching for a new start bit.
- R10: A frame with a low stop bit and non-zero data is stored with bit 9 set, and the framing flag is set.
- R11: irq equals (rx_int_en AND (trigger OR timeout)) OR (err_int_en AND (overrun OR break OR framing)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial line, idle high |
| rate_div | input | 8 | Sample tick divisor minus one |
| trig_code | input | 3 | Trigger threshold code |
| tmo_code | input | 2 | Inactivity timeout code |
| rx_int_en | input | 1 | Enable for trigger and timeout interrupts |
| err_int_en | input | 1 | Enable for error-flag interrupts |
| rd_en | input | 1 | Pop the queue head |
| rd_word | output | 32 | Queue head with flags |
| clr_wr | input | 1 | Write strobe for flag clear |
| clr_data | input | 8 | Write-1-to-clear mask (bits 5..3) |
| status | output | 8 | Bit 5 overrun, 4 break, 3 framing, 2 timeout, 1 trigger |
| level | output | 8 | Queue occupancy |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume three things about the inputs:
- rate_div, trig_code and tmo_code change only while the line is idle and the checks in progress do not depend on them;
- rd_en is raised only between frames;
- rx_line holds each bit for a whole 14-tick period.

The stimulus drives every bit for exactly 14 × (rate_div + 1) clocks. It changes settings only after a frame has completed, and it pops only after the line has been idle for two bit periods. The timeout check therefore measures the quiet interval from the end of a frame.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_RECOVER
    } rx_state_e;

    typedef struct packed {
        logic       brk;
        logic       ferr;
        logic [7:0] data;
    } rx_entry_t;

    function automatic logic [7:0] trig_threshold(input logic [2:0] code);
        case (code)
            3'd0:    return 8'd1;
            3'd1:    return 8'd4;
            3'd2:    return 8'd8;
            3'd3:    return 8'd16;
            3'd4:    return 8'd32;
            default: return 8'd48;
        endcase
    endfunction

    function automatic logic [4:0] tmo_chars(input logic [1:0] code);
        case (code)
            2'd1:    return 5'd4;
            2'd2:    return 5'd8;
            2'd3:    return 5'd16;
            default: return 5'd0;
        endcase
    endfunction

endpackage

// File: rtl/serial_rx_tick.sv
module serial_rx_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt <= '0;
        else if (hold || cnt == div) cnt <= '0;
        else                         cnt <= cnt + 1'b1;
    end

    assign tick = !hold && (cnt == div);

endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
    import serial_rx_pkg::*;
#(
    parameter int OSR       = 14,
    parameter int DATA_BITS = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rx_line,
    input  logic      tick,
    output logic      busy,
    output logic      push,
    output rx_entry_t entry
);
    localparam int TCW = $clog2(OSR);
    localparam int BCW = $clog2(DATA_BITS + 1);
    localparam int MID = OSR / 2;

    rx_state_e state, state_nx;
    logic [1:0]           sync_q;
    logic                 rxs;
    logic [TCW-1:0]       tcnt;
    logic [BCW-1:0]       bitn;
    logic [DATA_BITS-1:0] shreg;
    logic                 start_chk, bit_end, last_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rx_line};
    end
    assign rxs = sync_q[1];

    assign start_chk = tick && (tcnt == TCW'(MID - 1));
    assign bit_end   = tick && (tcnt == TCW'(OSR - 1));
    assign last_bit  = (bitn == BCW'(DATA_BITS - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE:    if (!rxs) state_nx = RX_START;
            RX_START:   if (start_chk) state_nx = rxs ? RX_IDLE : RX_DATA;
            RX_DATA:    if (bit_end && last_bit) state_nx = RX_STOP;
            RX_STOP:    if (bit_end) state_nx = rxs ? RX_IDLE : RX_RECOVER;
            RX_RECOVER: if (rxs) state_nx = RX_IDLE;
            default:    state_nx = RX_IDLE;
        endcase
    end

    // counters, shifter and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt  <= '0;
            bitn  <= '0;
            shreg <= '0;
            push  <= 1'b0;
            entry <= '0;
        end else begin
            push <= 1'b0;
            if (state == RX_IDLE) begin
                tcnt <= '0;
                bitn <= '0;
            end else if (tick) begin
                if ((state == RX_START && start_chk) || bit_end) tcnt <= '0;
                else                                             tcnt <= tcnt + 1'b1;
            end
            if (state == RX_DATA && bit_end) begin
                shreg <= {rxs, shreg[DATA_BITS-1:1]};
                bitn  <= bitn + 1'b1;
            end
            if (state == RX_STOP && bit_end) begin
                push       <= 1'b1;
                entry.data <= shreg;
                entry.brk  <= !rxs && (shreg == '0);
                entry.ferr <= !rxs && (shreg != '0);
            end
        end
    end

    assign busy = (state != RX_IDLE);

    a_r9_flag_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !(entry.brk && entry.ferr));
    a_r2_push_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(push) |-> ($past(state) == RX_STOP));

endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 10,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    a_r7_full_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (count == CW'(DEPTH)));

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import serial_rx_pkg::*;
#(
    parameter int OSR        = 14,
    parameter int FIFO_DEPTH = 64,
    parameter int DIV_W      = 8,
    parameter int TMO_W      = 12,
    localparam int CHAR_TICKS = OSR * 10,
    localparam int CW         = $clog2(FIFO_DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_line,
    input  logic [DIV_W-1:0] rate_div,
    input  logic [2:0]       trig_code,
    input  logic [1:0]       tmo_code,
    input  logic             rx_int_en,
    input  logic             err_int_en,
    input  logic             rd_en,
    output logic [31:0]      rd_word,
    input  logic             clr_wr,
    input  logic [7:0]       clr_data,
    output logic [7:0]       status,
    output logic [7:0]       level,
    output logic             irq
);
    logic       sym_tick, free_tick, busy, push, empty, full;
    rx_entry_t  entry, head;
    logic [CW-1:0]    count;
    logic [TMO_W-1:0] tmo_cnt, tmo_limit;
    logic       oe_q, brk_q, fe_q, trig_hit, tmo_hit, ovf_evt;
    logic       unused_clr;

    assign unused_clr = ^{clr_data[7:6], clr_data[2:0]};

    serial_rx_tick #(.DIV_W(DIV_W)) u_sym_tick (
        .clk(clk), .rst_n(rst_n), .hold(!busy), .div(rate_div), .tick(sym_tick));

    serial_rx_tick #(.DIV_W(DIV_W)) u_free_tick (
        .clk(clk), .rst_n(rst_n), .hold(1'b0), .div(rate_div), .tick(free_tick));

    serial_rx_frame #(.OSR(OSR), .DATA_BITS(8)) u_frame (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick(sym_tick),
        .busy(busy), .push(push), .entry(entry));

    serial_rx_fifo #(.DEPTH(FIFO_DEPTH), .W($bits(rx_entry_t))) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .wdata(entry), .pop(rd_en),
        .rdata(head), .empty(empty), .full(full), .count(count));

    assign level   = 8'(count);
    assign rd_word = empty ? 32'h0000_0100
                           : {21'b0, head.brk, head.ferr, 1'b0, head.data};

    // trigger and inactivity timeout
    assign trig_hit  = (level >= trig_threshold(trig_code));
    assign tmo_limit = TMO_W'(tmo_chars(tmo_code)) * TMO_W'(CHAR_TICKS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tmo_cnt <= '0;
        else if (busy || push || rd_en || empty)
            tmo_cnt <= '0;
        else if (free_tick && tmo_cnt < tmo_limit)
            tmo_cnt <= tmo_cnt + 1'b1;
    end
    assign tmo_hit = (tmo_code != 2'd0) && !empty && (tmo_cnt >= tmo_limit);

    // sticky error flags, set wins over clear
    assign ovf_evt = push && full;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q  <= 1'b0;
            brk_q <= 1'b0;
            fe_q  <= 1'b0;
        end else begin
            oe_q  <= ovf_evt                 || (oe_q  && !(clr_wr && clr_data[5]));
            brk_q <= (push && entry.brk)     || (brk_q && !(clr_wr && clr_data[4]));
            fe_q  <= (push && entry.ferr)    || (fe_q  && !(clr_wr && clr_data[3]));
        end
    end

    assign status = {2'b00, oe_q, brk_q, fe_q, tmo_hit, trig_hit, 1'b0};
    assign irq    = (rx_int_en  && (trig_hit || tmo_hit)) ||
                    (err_int_en && (oe_q || brk_q || fe_q));

    a_r11_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_int_en && !err_int_en) |-> !irq);
    a_r3_empty_word: assert property (@(posedge clk) disable iff (!rst_n)
        (level == 8'd0) |-> (rd_word == 32'h100));
    a_r6_clear_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_data[5] && !ovf_evt) |=> !status[5]);
    a_r5_timeout_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        status[2] |-> (level != 8'd0));

endmodule

// File: tb/serial_rx_core_tb.sv
module serial_rx_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_line = 1'b1;
    logic [7:0]  rate_div = 8'd0;
    logic [2:0]  trig_code = 3'd5;
    logic [1:0]  tmo_code = 2'd0;
    logic        rx_int_en = 1'b0, err_int_en = 1'b0, rd_en = 1'b0;
    logic        clr_wr = 1'b0;
    logic [7:0]  clr_data = 8'd0;
    logic [31:0] rd_word;
    logic [7:0]  status, level;
    logic        irq;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    serial_rx_core u_dut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .rate_div(rate_div),
        .trig_code(trig_code), .tmo_code(tmo_code), .rx_int_en(rx_int_en),
        .err_int_en(err_int_en), .rd_en(rd_en), .rd_word(rd_word),
        .clr_wr(clr_wr), .clr_data(clr_data), .status(status),
        .level(level), .irq(irq));

    // {byte[19:12], stop bit[11], expected word[10:0]}
    localparam logic [19:0] VECS [0:7] = '{
        {8'h55, 1'b1, 11'h055},
        {8'hA3, 1'b1, 11'h0A3},
        {8'hFF, 1'b1, 11'h0FF},
        {8'h01, 1'b1, 11'h001},
        {8'h80, 1'b1, 11'h080},
        {8'h3C, 1'b0, 11'h23C},
        {8'h00, 1'b0, 11'h400},
        {8'h00, 1'b1, 11'h000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input logic stopb);
        int bc;
        bc = 14 * (int'(rate_div) + 1);
        @(negedge clk) rx_line = 1'b0;
        repeat (bc) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_line = b[i];
            repeat (bc) @(negedge clk);
        end
        rx_line = stopb;
        repeat (bc) @(negedge clk);
        rx_line = 1'b1;
        repeat (2 * bc) @(negedge clk);
    endtask

    task automatic pop(output logic [31:0] w);
        @(negedge clk);
        w = rd_word;
        rd_en = 1'b1;
        @(negedge clk) rd_en = 1'b0;
    endtask

    task automatic clear(input logic [7:0] m);
        @(negedge clk) begin clr_wr = 1'b1; clr_data = m; end
        @(negedge clk) begin clr_wr = 1'b0; clr_data = 8'd0; end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] w;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // reset state
        check("R3 reset empty word", rd_word, 32'h100);
        check("R8 reset level", {24'd0, level}, 32'd0);
        check("R6 reset status", {24'd0, status}, 32'd0);
        check("R11 reset irq", {31'd0, irq}, 32'd0);

        // glitch rejection
        @(negedge clk) rx_line = 1'b0;
        repeat (3) @(negedge clk);
        rx_line = 1'b1;
        repeat (60) @(negedge clk);
        check("R2 glitch ignored", {24'd0, level}, 32'd0);

        // vector table
        for (int v = 0; v < 8; v++) begin
            send(VECS[v][19:12], VECS[v][11]);
            pop(w);
            check("R1/R3/R9/R10 vector word", w, {21'd0, VECS[v][10:0]});
        end
        check("R6 flags after vectors", {29'd0, status[5:3]}, 32'b011);
        clear(8'h08);
        check("R6 framing cleared", {29'd0, status[5:3]}, 32'b010);
        clear(8'h10);
        check("R6 break cleared", {29'd0, status[5:3]}, 32'b000);

        // trigger threshold and order
        trig_code = 3'd2;
        for (int i = 0; i < 7; i++) send(8'h10 + 8'(i), 1'b1);
        check("R4 below threshold", {31'd0, status[1]}, 32'd0);
        check("R8 level 7", {24'd0, level}, 32'd7);
        send(8'h17, 1'b1);
        check("R4 at threshold", {31'd0, status[1]}, 32'd1);
        check("R11 irq disabled", {31'd0, irq}, 32'd0);
        rx_int_en = 1'b1;
        @(negedge clk);
        check("R11 irq trigger", {31'd0, irq}, 32'd1);
        rx_int_en = 1'b0;
        for (int i = 0; i < 8; i++) begin
            pop(w);
            check("R8 order", w, 32'h10 + 32'(i));
        end
        pop(w);
        check("R3 empty read", w, 32'h100);
        check("R3 empty pop level", {24'd0, level}, 32'd0);

        // inactivity timeout, code 1 = 560 ticks
        trig_code = 3'd5;
        tmo_code = 2'd1;
        send(8'h5A, 1'b1);
        repeat (300) @(negedge clk);
        check("R5 timeout not yet", {31'd0, status[2]}, 32'd0);
        repeat (400) @(negedge clk);
        check("R5 timeout raised", {31'd0, status[2]}, 32'd1);
        pop(w);
        check("R5 byte", w, 32'h5A);
        check("R5 timeout dropped", {31'd0, status[2]}, 32'd0);
        tmo_code = 2'd0;

        // overrun
        for (int i = 0; i < 65; i++) send(8'(i), 1'b1);
        check("R8 full level", {24'd0, level}, 32'd64);
        check("R7 overrun flag", {31'd0, status[5]}, 32'd1);
        err_int_en = 1'b1;
        @(negedge clk);
        check("R11 irq error", {31'd0, irq}, 32'd1);
        for (int i = 0; i < 64; i++) begin
            pop(w);
            if (i == 0 || i == 63) check("R7 kept bytes", w, 32'(i));
        end
        clear(8'h20);
        check("R6 overrun cleared", {31'd0, status[5]}, 32'd0);
        check("R11 irq after clear", {31'd0, irq}, 32'd0);
        err_int_en = 1'b0;

        // divisor 2
        rate_div = 8'd2;
        send(8'hC6, 1'b1);
        pop(w);
        check("R1 divided rate", w, 32'hC6);

        finish_run();
    end
endmodule